// File: doc/BRIEF.md
# Consecutive Search Key Comparator for Selective Match-Line Precharge

This block sits in front of the search-line driver of a ternary content-addressable lookup array. It keeps the two most recent search keys in registers and compares them on the columns that hold no don't-care cell in any stored entry. Those columns come from a mask input. A key that agrees with its predecessor on every compared column can only hit the entries that hit last time. A key that disagrees can only hit entries that missed last time. The block uses this to choose which match lines are worth precharging.

The result is an active-low precharge enable for each entry. When the keys agree, the block takes the inverse of the previous match vector. When they disagree, it takes that vector unchanged. When the key has no valid predecessor, every line is precharged. The key is forwarded to the search-line driver two clocks after it is presented. Keys may arrive back to back, one per cycle.

Top module: `keyseq_top`

## Requirements
- R1: A key presented with `key_vld` high in cycle t appears on `sl_key` with `sl_vld` high in cycle t+2, that is, after the second rising edge. Back-to-back keys give one forwarded key per cycle.
- R2: For a key with a valid predecessor, `same_key` is high exactly when the two keys are equal on every column whose `col_mask` bit is 0. A mask bit of 1 excludes that column. The mask is sampled in cycle t+1.
- R3: When `same_key` is high, `pre_n` equals the bitwise inverse of the `prev_match` value sampled in cycle t+1. Bit i low means entry i is precharged, so only entries that matched before are precharged.
- R4: When a key has a valid predecessor and `same_key` is low, `pre_n` equals the `prev_match` value sampled in cycle t+1. Only entries that missed before are precharged.
- R5: For a valid key with no valid key in the cycle just before it (the first key after reset, or the first key after a gap), `pre_n` is all zeros and `same_key` is low.
- R6: In a cycle where `sl_vld` is low, `pre_n` is all ones and `same_key` is low.
- R7: While reset is applied, and on the cycle after it, `sl_vld` and `same_key` are 0, `pre_n` is all ones and `sl_key` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_in | input | KEY_W | Incoming search key |
| key_vld | input | 1 | Search key valid strobe |
| col_mask | input | KEY_W | Columns to exclude from the comparison (1 = excluded) |
| prev_match | input | ENTRIES | Match result of the previous search, one bit per entry |
| same_key | output | 1 | Consecutive masked keys are equal |
| pre_n | output | ENTRIES | Active-low precharge enable, one bit per entry |
| sl_key | output | KEY_W | Key forwarded to the search-line driver |
| sl_vld | output | 1 | Forwarded key valid |

## Verification
The assertions assume that `key_vld` is a clean strobe. They also assume that `prev_match` and `col_mask` are sampled one cycle before the result appears. They do not assume any relation between `prev_match` and the keys, because array sensing lies outside this block.

The stimulus covers several cases:
- A mask held through bursts, with keys that differ only in excluded columns and keys that differ in compared columns.
- An all-zero mask and an all-ones mask.
- Gaps of different lengths, which separate first keys from paired keys.
- A long stretch with random strobes, keys and match vectors.

// File: rtl/keyseq_pkg.sv
`timescale 1ns/1ps
package keyseq_pkg;

    localparam int KEY_W_DFLT   = 64;
    localparam int ENTRIES_DFLT = 12;

    // Which group of match lines is precharged for the next search
    typedef enum logic [1:0] {
        PC_NONE = 2'd0,   // no search this cycle
        PC_ALL  = 2'd1,   // no usable history: precharge every line
        PC_HIT  = 2'd2,   // same masked key: previously matched lines
        PC_MISS = 2'd3    // new masked key: previously missed lines
    } pc_mode_e;

    function automatic pc_mode_e pick_mode(input logic cur_v,
                                           input logic prv_v,
                                           input logic same);
        pc_mode_e m;
        if (!cur_v)      m = PC_NONE;
        else if (!prv_v) m = PC_ALL;
        else if (same)   m = PC_HIT;
        else             m = PC_MISS;
        return m;
    endfunction

endpackage

// File: rtl/keyseq_hold.sv
`timescale 1ns/1ps
module keyseq_hold #(
    parameter int KEY_W = keyseq_pkg::KEY_W_DFLT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [KEY_W-1:0] key_in,
    input  logic             key_vld,
    output logic [KEY_W-1:0] cur_key,
    output logic             cur_vld,
    output logic [KEY_W-1:0] prv_key,
    output logic             prv_vld
);
    // The newest key lands in the current stage; the stage before it
    // shifts into the previous stage on every clock.
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_key <= '0;
            cur_vld <= 1'b0;
            prv_key <= '0;
            prv_vld <= 1'b0;
        end else begin
            cur_key <= key_in;
            cur_vld <= key_vld;
            prv_key <= cur_key;
            prv_vld <= cur_vld;
        end
    end
endmodule

// File: rtl/keyseq_maskcmp.sv
`timescale 1ns/1ps
module keyseq_maskcmp #(
    parameter int KEY_W = keyseq_pkg::KEY_W_DFLT
) (
    input  logic [KEY_W-1:0] key_a,
    input  logic [KEY_W-1:0] key_b,
    input  logic [KEY_W-1:0] col_mask,
    output logic             same
);
    logic [KEY_W-1:0] col_diff;

    // A column counts as a difference only when it is not excluded.
    for (genvar c = 0; c < KEY_W; c++) begin : g_col
        assign col_diff[c] = (key_a[c] ^ key_b[c]) & ~col_mask[c];
    end

    assign same = ~|col_diff;
endmodule

// File: rtl/keyseq_pcsel.sv
`timescale 1ns/1ps
module keyseq_pcsel #(
    parameter int ENTRIES = keyseq_pkg::ENTRIES_DFLT
) (
    input  keyseq_pkg::pc_mode_e mode,
    input  logic [ENTRIES-1:0]   prev_match,
    output logic [ENTRIES-1:0]   pre_n
);
    import keyseq_pkg::*;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        always_comb begin
            unique case (mode)
                PC_ALL:  pre_n[e] = 1'b0;
                PC_HIT:  pre_n[e] = ~prev_match[e];
                PC_MISS: pre_n[e] = prev_match[e];
                default: pre_n[e] = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/keyseq_top.sv
`timescale 1ns/1ps
module keyseq_top #(
    parameter int KEY_W   = keyseq_pkg::KEY_W_DFLT,
    parameter int ENTRIES = keyseq_pkg::ENTRIES_DFLT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [KEY_W-1:0]   key_in,
    input  logic               key_vld,
    input  logic [KEY_W-1:0]   col_mask,
    input  logic [ENTRIES-1:0] prev_match,
    output logic               same_key,
    output logic [ENTRIES-1:0] pre_n,
    output logic [KEY_W-1:0]   sl_key,
    output logic               sl_vld
);
    import keyseq_pkg::*;

    logic [KEY_W-1:0]   cur_key, prv_key;
    logic               cur_vld, prv_vld;
    logic               keys_eq;
    pc_mode_e           mode;
    logic [ENTRIES-1:0] pre_n_d;

    keyseq_hold #(.KEY_W(KEY_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .key_in  (key_in),
        .key_vld (key_vld),
        .cur_key (cur_key),
        .cur_vld (cur_vld),
        .prv_key (prv_key),
        .prv_vld (prv_vld)
    );

    keyseq_maskcmp #(.KEY_W(KEY_W)) u_cmp (
        .key_a    (cur_key),
        .key_b    (prv_key),
        .col_mask (col_mask),
        .same     (keys_eq)
    );

    assign mode = pick_mode(cur_vld, prv_vld, keys_eq);

    keyseq_pcsel #(.ENTRIES(ENTRIES)) u_sel (
        .mode       (mode),
        .prev_match (prev_match),
        .pre_n      (pre_n_d)
    );

    // Output stage feeding the search-line driver and precharge drivers
    always_ff @(posedge clk) begin
        if (rst) begin
            same_key <= 1'b0;
            pre_n    <= '1;
            sl_key   <= '0;
            sl_vld   <= 1'b0;
        end else begin
            same_key <= (mode == PC_HIT);
            pre_n    <= pre_n_d;
            sl_key   <= cur_key;
            sl_vld   <= cur_vld;
        end
    end
endmodule

// File: rtl/keyseq_top_chk.sv
`timescale 1ns/1ps
module keyseq_top_chk #(
    parameter int KEY_W   = 64,
    parameter int ENTRIES = 12
) (
    input logic               clk,
    input logic               rst,
    input logic [KEY_W-1:0]   key_in,
    input logic               key_vld,
    input logic [KEY_W-1:0]   col_mask,
    input logic [ENTRIES-1:0] prev_match,
    input logic               same_key,
    input logic [ENTRIES-1:0] pre_n,
    input logic [KEY_W-1:0]   sl_key,
    input logic               sl_vld
);
    // Delayed copies of the inputs, used only for the assertions below
    logic [KEY_W-1:0]   k1, k2, k3, m1;
    logic               v1, v2, v3;
    logic [ENTRIES-1:0] p1;

    always_ff @(posedge clk) begin
        if (rst) begin
            k1 <= '0; k2 <= '0; k3 <= '0; m1 <= '0;
            v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0; p1 <= '0;
        end else begin
            k1 <= key_in; k2 <= k1; k3 <= k2;
            v1 <= key_vld; v2 <= v1; v3 <= v2;
            m1 <= col_mask; p1 <= prev_match;
        end
    end

    AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        sl_vld == v2);                                                          // R1
    AST_KEY_LATENCY: assert property (@(posedge clk) disable iff (rst)
        sl_vld |-> sl_key == k2);                                               // R1
    AST_MASKED_EQ: assert property (@(posedge clk) disable iff (rst)
        (sl_vld && v3) |-> same_key == (((k2 ^ k3) & ~m1) == '0));              // R2
    AST_HIT_LINES: assert property (@(posedge clk) disable iff (rst)
        (sl_vld && same_key) |-> pre_n == ~p1);                                 // R3
    AST_MISS_LINES: assert property (@(posedge clk) disable iff (rst)
        (sl_vld && v3 && !same_key) |-> pre_n == p1);                           // R4
    AST_FIRST_ALL: assert property (@(posedge clk) disable iff (rst)
        (sl_vld && !v3) |-> (pre_n == '0 && !same_key));                        // R5
    AST_IDLE_NONE: assert property (@(posedge clk) disable iff (rst)
        !sl_vld |-> (pre_n == '1 && !same_key));                                // R6
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!sl_vld && !same_key && pre_n == '1 && sl_key == '0));         // R7
endmodule

bind keyseq_top keyseq_top_chk #(.KEY_W(KEY_W), .ENTRIES(ENTRIES)) u_chk (
    .clk(clk), .rst(rst), .key_in(key_in), .key_vld(key_vld),
    .col_mask(col_mask), .prev_match(prev_match), .same_key(same_key),
    .pre_n(pre_n), .sl_key(sl_key), .sl_vld(sl_vld)
);

// File: tb/keyseq_top_test.sv
`timescale 1ns/1ps
module keyseq_top_test;
    localparam int KW = 64;
    localparam int NE = 12;

    logic          clk = 1'b0;
    logic          rst;
    logic [KW-1:0] key_in, col_mask;
    logic          key_vld;
    logic [NE-1:0] prev_match;
    logic          same_key, sl_vld;
    logic [NE-1:0] pre_n;
    logic [KW-1:0] sl_key;

    always #5 clk = ~clk;

    keyseq_top #(.KEY_W(KW), .ENTRIES(NE)) uut (
        .clk(clk), .rst(rst), .key_in(key_in), .key_vld(key_vld),
        .col_mask(col_mask), .prev_match(prev_match), .same_key(same_key),
        .pre_n(pre_n), .sl_key(sl_key), .sl_vld(sl_vld)
    );

    // History of every input set the design has sampled, oldest first
    logic [KW-1:0] hk[$];
    logic [KW-1:0] hm[$];
    logic          hv[$];
    logic [NE-1:0] hp[$];

    int errs   = 0;
    int checks = 0;
    bit done   = 0;

    task automatic expect_eq(string req, string what, logic [KW-1:0] act, logic [KW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference: outputs now reflect key L-2, its predecessor L-3,
    // and the mask / match vector from L-1.
    task automatic check_cycle();
        int L = hk.size();
        bit cv, pv, eq;
        logic [NE-1:0] ep;
        cv = (L >= 2) ? hv[L-2] : 1'b0;
        pv = (L >= 3) ? hv[L-3] : 1'b0;
        if (!cv) begin
            expect_eq("R6", "sl_vld", KW'(sl_vld), KW'(0));
            expect_eq("R6", "same_key", KW'(same_key), KW'(0));
            expect_eq("R6", "pre_n", KW'(pre_n), KW'({NE{1'b1}}));
        end else begin
            expect_eq("R1", "sl_vld", KW'(sl_vld), KW'(1));
            expect_eq("R1", "sl_key", sl_key, hk[L-2]);
            if (!pv) begin
                expect_eq("R5", "same_key", KW'(same_key), KW'(0));
                expect_eq("R5", "pre_n", KW'(pre_n), KW'(0));
            end else begin
                eq = (((hk[L-2] ^ hk[L-3]) & ~hm[L-1]) == '0);
                ep = eq ? ~hp[L-1] : hp[L-1];
                expect_eq("R2", "same_key", KW'(same_key), KW'(eq));
                if (eq) expect_eq("R3", "pre_n", KW'(pre_n), KW'(ep));
                else    expect_eq("R4", "pre_n", KW'(pre_n), KW'(ep));
            end
        end
    endtask

    task automatic drive(logic r, logic v, logic [KW-1:0] k, logic [KW-1:0] m, logic [NE-1:0] p);
        rst = r; key_vld = v; key_in = k; col_mask = m; prev_match = p;
        hk.push_back(k); hm.push_back(r ? '0 : m);
        hv.push_back(r ? 1'b0 : v); hp.push_back(p);
    endtask

    task automatic step(logic v, logic [KW-1:0] k, logic [KW-1:0] m, logic [NE-1:0] p);
        @(negedge clk);
        check_cycle();
        drive(1'b0, v, k, m, p);
    endtask

    localparam logic [KW-1:0] MSK = 64'hF000_0000_00FF_0000;
    localparam logic [KW-1:0] KA  = 64'h0123_4567_89AB_CDEF;

    initial begin
        drive(1'b1, 1'b1, KA, MSK, 12'hABC);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            // R7: reset state
            expect_eq("R7", "sl_vld", KW'(sl_vld), KW'(0));
            expect_eq("R7", "same_key", KW'(same_key), KW'(0));
            expect_eq("R7", "pre_n", KW'(pre_n), KW'({NE{1'b1}}));
            expect_eq("R7", "sl_key", sl_key, '0);
            drive(1'b1, 1'b1, KA, MSK, 12'hABC);
        end
        // first key after reset (R5), then repeats (R3)
        step(1'b1, KA, MSK, 12'h00F);
        step(1'b1, KA, MSK, 12'h0F0);
        step(1'b1, KA, MSK, 12'hF00);
        step(1'b1, KA, MSK, 12'h5A5);
        // differ only in excluded columns: still equal (R2, R3)
        step(1'b1, KA ^ 64'h9000_0000_0012_0000, MSK, 12'h333);
        step(1'b1, KA ^ 64'h6000_0000_00ED_0000, MSK, 12'hC3C);
        // differ in compared columns (R4)
        step(1'b1, KA ^ 64'h0000_0000_0000_0001, MSK, 12'h0FF);
        step(1'b1, KA ^ 64'h0800_0000_0000_0000, MSK, 12'h700);
        // gaps of one and two cycles, then first keys (R5, R6)
        step(1'b0, KA, MSK, 12'h111);
        step(1'b1, KA, MSK, 12'h222);
        step(1'b0, KA, MSK, 12'h333);
        step(1'b0, KA, MSK, 12'h444);
        step(1'b1, KA, MSK, 12'h555);
        step(1'b1, KA, MSK, 12'h666);
        // all-zero mask: every column compared
        for (int i = 0; i < 3; i++) step(1'b0, KA, '0, 12'h000);
        step(1'b1, KA, '0, 12'h0A0);
        step(1'b1, KA, '0, 12'h123);
        step(1'b1, KA ^ 64'h8000_0000_0000_0000, '0, 12'h456);
        step(1'b1, KA ^ 64'h8000_0000_0000_0000, '0, 12'h789);
        // all-ones mask: every pair counts as equal
        for (int i = 0; i < 3; i++) step(1'b0, KA, '1, 12'h000);
        step(1'b1, 64'h0, '1, 12'h0F0);
        step(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, '1, 12'hA5A);
        step(1'b1, 64'h1234, '1, 12'hFFF);
        // random burst traffic with occasional mask changes during gaps
        begin
            logic [KW-1:0] m = MSK;
            logic [KW-1:0] pool[4];
            pool[0] = KA;
            pool[1] = KA ^ 64'h1000_0000_0001_0000;
            pool[2] = KA ^ 64'h0000_0001_0000_0000;
            pool[3] = {$urandom, $urandom};
            for (int i = 0; i < 400; i++) begin
                logic v = ($urandom_range(0, 9) < 8);
                if (!v && ($urandom_range(0, 7) == 0))
                    m = {$urandom, $urandom} & {$urandom, $urandom};
                step(v, pool[$urandom_range(0, 3)], m, NE'($urandom));
            end
        end
        for (int i = 0; i < 3; i++) step(1'b0, '0, MSK, '0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule